// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block derives two audio clocks from one fast system clock. A fractional rate divider adds an 8-bit numerator to an accumulator on every system clock cycle. Each time the sum reaches the 8-bit denominator, the divider subtracts the denominator and issues a tick. Every tick toggles the main clock, so the main clock runs at half the tick rate and its duty cycle stays close to even. An integer divider then counts main clock toggles to produce a bit clock whose period is a programmable number of main clock periods.

All outputs are registers clocked by the system clock, so every transition lies on a system clock edge. When the denominator is not a multiple of the numerator, the main clock therefore shows cycle-to-cycle jitter, but its average frequency is exact. When the denominator is a multiple of the numerator, the output is strictly periodic. Each clock has a companion strobe that is high for one system clock cycle, the first cycle the clock is high. Downstream logic can use the strobes as synchronous enables.

Settings outside the legal range hold both clocks low and raise an error flag. These are a zero numerator, a zero denominator, or a numerator larger than the denominator. Dropping the enable clears all internal state, so every restart produces the same first edge.

Top module: `audio_clkgen`

## Requirements
- R1: When `num_x` is 0, `den_y` is 0, or `num_x` > `den_y`, `cfg_err` is 1 in that same cycle. From the next system clock edge on, `mclk_o`, `bclk_o`, `mclk_stb` and `bclk_stb` stay 0. With a legal setting, `cfg_err` is 0.
- R2: Start from a cleared state with a legal setting X/Y held constant. Over the first Y·K system clock cycles with `en` high (K even), `mclk_o` makes exactly X·K/2 rising transitions. Its average frequency is therefore clk·X/(2Y).
- R3: When Y is an exact multiple of X, `mclk_o` changes value on exactly the clock edges whose index (counted from 1 after `en` rises) is a multiple of Y/X. When X equals Y, it changes on every edge.
- R4: `bclk_o` changes value once for every N+1 changes of `mclk_o`, where N is `bdiv_n`. Its period is therefore N+1 main clock periods. While the block runs, `bclk_o` changes only on edges where `mclk_o` also changes.
- R5: With `bdiv_n` equal to 0, `bclk_o` equals `mclk_o` on every cycle.
- R6: `mclk_stb` is 1 exactly in the cycles where `mclk_o` is 1 and was 0 in the previous cycle. `bclk_stb` follows the same rule with respect to `bclk_o`.
- R7: An edge that samples `en` low forces all four clock outputs and strobes to 0. After `en` is raised again, the first rising transition of `mclk_o` appears on edge number ceil(Y/X).
- R8: An asserted `rst_n` (active low, asynchronous) immediately forces all clock outputs and strobes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears accumulator, toggles and counter |
| num_x | input | 8 | Fractional divider numerator X, legal 1..Y |
| den_y | input | 8 | Fractional divider denominator Y, legal 1..255 |
| bdiv_n | input | 8 | Bit clock divide value N, ratio N+1 |
| mclk_o | output | 1 | Main audio clock, average clk·X/(2Y) |
| bclk_o | output | 1 | Bit clock, main clock divided by N+1 |
| mclk_stb | output | 1 | One-cycle pulse on the first high cycle of `mclk_o` |
| bclk_stb | output | 1 | One-cycle pulse on the first high cycle of `bclk_o` |
| cfg_err | output | 1 | High while X/Y is an illegal setting |

## Verification
The bound checker runs on every cycle and covers these properties:
- the error flag and the silenced outputs for illegal settings;
- the clearing effect of a low enable;
- both strobes lining up with rising clock transitions;
- the bit clock never changing apart from the main clock while running;
- the every-edge toggling when X equals Y.

Some behaviours need a counted window, so only the bench's sweeps can show them:
- the exact edge count over Y·K cycles;
- the strict Y/X toggle spacing for divisible ratios;
- the bit clock toggle count for each N;
- the position of the first edge after a restart.

The bench sweeps all legal X/Y pairs up to a small denominator, for several N, and adds the extreme 8-bit settings.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] num_x,
  input  logic [W-1:0] den_y,
  input  logic [W-1:0] bdiv_n,
  output logic         mclk_o,
  output logic         bclk_o,
  output logic         mclk_stb,
  output logic         bclk_stb,
  output logic         cfg_err
);

  logic [W-1:0] acc;
  logic [W-1:0] tcnt;
  logic [W:0]   sum;
  logic         tick;
  logic         wrap;
  logic         run;

  assign cfg_err = (num_x == '0) || (den_y == '0) || (num_x > den_y);
  assign run     = en && !cfg_err;
  assign sum     = {1'b0, acc} + {1'b0, num_x};
  assign tick    = sum >= {1'b0, den_y};
  assign wrap    = tcnt == bdiv_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      tcnt     <= '0;
      mclk_o   <= 1'b0;
      bclk_o   <= 1'b0;
      mclk_stb <= 1'b0;
      bclk_stb <= 1'b0;
    end else if (!run) begin
      acc      <= '0;
      tcnt     <= '0;
      mclk_o   <= 1'b0;
      bclk_o   <= 1'b0;
      mclk_stb <= 1'b0;
      bclk_stb <= 1'b0;
    end else begin
      acc      <= tick ? W'(sum - {1'b0, den_y}) : sum[W-1:0];
      mclk_stb <= tick && !mclk_o;
      bclk_stb <= tick && wrap && !bclk_o;
      if (tick) begin
        mclk_o <= !mclk_o;
        if (wrap) begin
          tcnt   <= '0;
          bclk_o <= !bclk_o;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] num_x,
  input logic [W-1:0] den_y,
  input logic         mclk_o,
  input logic         bclk_o,
  input logic         mclk_stb,
  input logic         bclk_stb,
  input logic         cfg_err
);

  logic bad;
  assign bad = (num_x == '0) || (den_y == '0) || (num_x > den_y);

  AST_BAD_CFG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> cfg_err); // R1
  AST_BAD_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (!mclk_o && !bclk_o && !mclk_stb && !bclk_stb)); // R1
  AST_X_EQ_Y_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && !bad && num_x == den_y) |-> !$stable(mclk_o)); // R3
  AST_BCLK_WITH_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bclk_o) && $past(en && !cfg_err)) |-> !$stable(mclk_o)); // R4
  AST_MSTB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_stb |-> (mclk_o && !$past(mclk_o))); // R6
  AST_BSTB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb |-> (bclk_o && !$past(bclk_o))); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!mclk_o && !bclk_o && !mclk_stb && !bclk_stb)); // R7

endmodule

bind audio_clkgen audio_clkgen_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .en(en), .num_x(num_x), .den_y(den_y),
  .mclk_o(mclk_o), .bclk_o(bclk_o), .mclk_stb(mclk_stb),
  .bclk_stb(bclk_stb), .cfg_err(cfg_err)
);

// File: tb/tb_audio_clkgen.sv
module tb_audio_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] num_x = 8'd0;
  logic [7:0] den_y = 8'd0;
  logic [7:0] bdiv_n = 8'd0;
  logic       mclk_o, bclk_o, mclk_stb, bclk_stb, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_clkgen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .num_x(num_x), .den_y(den_y),
    .bdiv_n(bdiv_n), .mclk_o(mclk_o), .bclk_o(bclk_o), .mclk_stb(mclk_stb),
    .bclk_stb(bclk_stb), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet_now(input string req);
    chk(req, {mclk_o, bclk_o, mclk_stb, bclk_stb}, 0, "outputs not all low");
  endtask

  task automatic window(input int x, input int y, input int n, input int k);
    int  mr = 0, bt = 0, first = -1;
    int  stb_bad = 0, bsync_bad = 0, eq_bad = 0, per_bad = 0;
    bit  pm = 0, pb = 0;
    en = 1'b0;
    @(negedge clk);
    num_x = 8'(x); den_y = 8'(y); bdiv_n = 8'(n); en = 1'b1;
    #0;
    chk("R1", cfg_err, 0, $sformatf("legal cfg_err x=%0d y=%0d", x, y));
    for (int c = 1; c <= y * k; c++) begin
      @(negedge clk);
      if (mclk_o && !pm) begin mr++; if (first < 0) first = c; end
      if (bclk_o != pb) begin bt++; if (mclk_o == pm) bsync_bad++; end
      if (mclk_stb != (mclk_o && !pm)) stb_bad++;
      if (bclk_stb != (bclk_o && !pb)) stb_bad++;
      if (n == 0 && bclk_o != mclk_o) eq_bad++;
      if (y % x == 0 && ((mclk_o != pm) != (c % (y / x) == 0))) per_bad++;
      pm = mclk_o; pb = bclk_o;
    end
    chk("R2", mr, x * k / 2, $sformatf("mclk rises x=%0d y=%0d", x, y));
    chk("R4", bt, (x * k) / (n + 1), $sformatf("bclk toggles x=%0d y=%0d n=%0d", x, y, n));
    chk("R4", bsync_bad, 0, "bclk change without mclk change");
    chk("R6", stb_bad, 0, "strobe mismatches");
    chk("R7", first, (y + x - 1) / x, $sformatf("first rise x=%0d y=%0d", x, y));
    if (n == 0) chk("R5", eq_bad, 0, "bclk differs from mclk");
    if (y % x == 0) chk("R3", per_bad, 0, $sformatf("period errors x=%0d y=%0d", x, y));
  endtask

  task automatic illegal(input int x, input int y);
    int hi = 0, flag_bad = 0;
    en = 1'b0;
    @(negedge clk);
    num_x = 8'(x); den_y = 8'(y); bdiv_n = 8'd0; en = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mclk_o || bclk_o || mclk_stb || bclk_stb) hi++;
      if (!cfg_err) flag_bad++;
    end
    chk("R1", hi, 0, $sformatf("active outputs x=%0d y=%0d", x, y));
    chk("R1", flag_bad, 0, $sformatf("cfg_err low x=%0d y=%0d", x, y));
  endtask

  initial begin
    #1;
    quiet_now("R8");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    quiet_now("R8");

    for (int n = 0; n <= 2; n++)
      for (int x = 1; x <= 8; x++)
        for (int y = x; y <= 12; y++)
          window(x, y, n, 2);
    window(255, 255, 0, 2);
    window(1, 255, 0, 2);
    window(200, 255, 3, 4);
    window(3, 9, 255, 2);

    illegal(0, 5);
    illegal(5, 0);
    illegal(6, 5);
    illegal(255, 254);

    // R7: disable mid-run clears outputs
    en = 1'b0;
    @(negedge clk);
    num_x = 8'd3; den_y = 8'd7; bdiv_n = 8'd0; en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", mclk_o, 1, "mclk high before disable");
    en = 1'b0;
    @(negedge clk);
    quiet_now("R7");

    // R8: asynchronous reset mid-run
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", mclk_o, 1, "mclk high before reset");
    rst_n = 1'b0;
    #1;
    quiet_now("R8");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule